// File: doc/BRIEF.md
# Flyback Soft-Start and Burst Mode Sequencer

This block is the digital mode sequencer of a current-mode flyback PWM controller. A power-good start pulse wakes it from idle. It then runs a soft-start phase. During that phase an 8-bit ramp code climbs step by step, and a downstream converter turns the code into the allowed duty and peak current. When the soft-start interval ends, the block hands control to normal operation. In normal operation the loop feedback sets the duty, and the current limit sits at its full level.

Light load is recognised when the feedback voltage stays under its lowest comparator threshold for a full qualification interval. The sequencer then moves to burst operation. In burst operation, switching runs in packets: a packet starts when the feedback climbs to the upper hysteresis flag and stops when it falls to the lower one, and the current limit drops to a reduced level. The sequencer returns to normal operation at once when the feedback crosses the highest threshold.

All four feedback inputs are comparator results that have already been synchronised. The block runs from a fixed timebase clock, and every interval in it is a parameterised count of that clock.

Top module: `flyback_mode_seq`

## Requirements
- R1: In the cycle after a synchronous reset or a shutdown, the block shows idle mode, gate disabled, limit select 2'b00 and ramp code zero. Shutdown takes priority over every other input, including a start pulse in the same cycle.
- R2: A start pulse seen in idle mode moves the block to soft start in the next cycle. A start pulse seen in any other mode has no effect.
- R3: In the k-th soft-start cycle, counting from 0, the ramp code equals min(floor(k/STEP), 2^CODE_W-1), where STEP = ceil(SS_CYCLES/(2^CODE_W-1)). Throughout soft start the gate is enabled and the limit select is 2'b01, meaning the limit follows the ramp.
- R4: Soft start lasts exactly SS_CYCLES cycles and is followed by normal mode. In normal mode the gate is enabled, the limit select is 2'b10 (full limit) and the ramp code holds full scale.
- R5: Normal mode moves to burst mode after the low-feedback flag has been sampled high in QUAL_CYCLES consecutive normal-mode cycles. A cycle with the flag low restarts the count, and cycles spent outside normal mode do not count.
- R6: Burst mode starts with the gate off. Inside burst mode, the burst-on flag turns the gate on and the burst-off flag turns it off. When neither flag is set the gate keeps its state, and when both are set the on flag wins.
- R7: In burst mode the limit select is 2'b11, the reduced limit.
- R8: While in burst mode, the exit flag moves the block to normal mode in the next cycle, whatever the other flags show. After that the gate is enabled and the limit select is back at 2'b10.
- R9: The mode output uses 2'b00 idle, 2'b01 soft start, 2'b10 normal and 2'b11 burst. Feedback flags have no effect in idle mode or in soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | Power-good start request |
| shutdown | input | 1 | Forced return to idle from protection logic |
| fbBelowEntry | input | 1 | Feedback below the burst entry threshold |
| fbAboveOn | input | 1 | Feedback above the upper hysteresis threshold |
| fbBelowOff | input | 1 | Feedback below the lower hysteresis threshold |
| fbAboveExit | input | 1 | Feedback above the burst exit threshold |
| mode | output | 2 | Operating mode code |
| gateEn | output | 1 | Enables switching cycles |
| limSel | output | 2 | Current-limit select (off, ramp, full, reduced) |
| ssCode | output | CODE_W | Soft-start ramp code |

## Verification
The bench provokes two same-cycle collisions. In the first, the exit flag and the burst-off flag are both set in one burst cycle while the gate is on. The bench judges this by confirming that the next cycle shows normal mode with the gate enabled and the full limit, rather than burst mode with the gate off. In the second, shutdown and a start pulse arrive together in idle mode. The bench requires the block to stay idle, and a later start pulse on its own must still launch soft start.

// File: rtl/fms_pkg.sv
package fms_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_SOFT   = 2'b01,
    MODE_NORMAL = 2'b10,
    MODE_BURST  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    LIM_OFF     = 2'b00,
    LIM_RAMP    = 2'b01,
    LIM_FULL    = 2'b10,
    LIM_REDUCED = 2'b11
  } lim_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;      // drop all counters and the ramp code
    logic ssAdvance;  // one soft-start cycle elapses
    logic ssFill;     // soft start ends: force code to full scale
    logic qualCount;  // normal mode with low feedback this cycle
  } dpStrobe_t;

endpackage

// File: rtl/fms_dp.sv
module fms_dp
  import fms_pkg::*;
#(
  parameter int SS_CYCLES   = 20000,
  parameter int QUAL_CYCLES = 20000,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  output logic              ssDone,
  output logic              qualDone,
  output logic [CODE_W-1:0] ssCode
);

  localparam int CODE_MAX_I = (1 << CODE_W) - 1;
  localparam int STEP       = (SS_CYCLES + CODE_MAX_I - 1) / CODE_MAX_I;
  localparam int STEP_W     = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int TIMER_W    = (SS_CYCLES > 1) ? $clog2(SS_CYCLES) : 1;
  localparam int QUAL_W     = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CODE_W-1:0]  CODE_MAX   = CODE_W'(CODE_MAX_I);
  localparam logic [STEP_W-1:0]  STEP_LAST  = STEP_W'(STEP - 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(SS_CYCLES - 1);
  localparam logic [QUAL_W-1:0]  QUAL_LAST  = QUAL_W'(QUAL_CYCLES - 1);

  logic [TIMER_W-1:0] ssTimer;
  logic [STEP_W-1:0]  stepCnt;
  logic [QUAL_W-1:0]  qualCnt;

  assign ssDone   = (ssTimer == TIMER_LAST);
  assign qualDone = (qualCnt == QUAL_LAST);

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      ssTimer <= '0;
      stepCnt <= '0;
    end else if (strobe.ssAdvance) begin
      ssTimer <= ssDone ? '0 : ssTimer + 1'b1;
      stepCnt <= (stepCnt == STEP_LAST) ? '0 : stepCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      ssCode <= '0;
    end else if (strobe.ssFill) begin
      ssCode <= CODE_MAX;
    end else if (strobe.ssAdvance && stepCnt == STEP_LAST && ssCode != CODE_MAX) begin
      ssCode <= ssCode + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear || !strobe.qualCount || qualDone) begin
      qualCnt <= '0;
    end else begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  // R3: the ramp never steps down while soft start runs
  p_code_monotonic_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.ssAdvance && !strobe.clear) |=> (ssCode >= $past(ssCode)));

  // R4: leaving soft start leaves the code at full scale
  p_code_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.ssFill && !strobe.clear) |=> (ssCode == CODE_MAX));

  // R1: a clear drops the ramp code
  p_code_clear_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (ssCode == '0));

endmodule

// File: rtl/fms_ctrl.sv
module fms_ctrl
  import fms_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startPulse,
  input  logic      shutdown,
  input  logic      fbBelowEntry,
  input  logic      fbAboveOn,
  input  logic      fbBelowOff,
  input  logic      fbAboveExit,
  input  logic      ssDone,
  input  logic      qualDone,
  output mode_e     modeQ,
  output logic      gateEn,
  output lim_e      limSel,
  output dpStrobe_t strobe
);

  mode_e modeNext;
  logic  burstOn, burstOnNext;

  always_comb begin
    modeNext    = modeQ;
    burstOnNext = burstOn;
    if (shutdown) begin
      modeNext    = MODE_IDLE;
      burstOnNext = 1'b0;
    end else begin
      case (modeQ)
        MODE_IDLE:   if (startPulse) modeNext = MODE_SOFT;
        MODE_SOFT:   if (ssDone) modeNext = MODE_NORMAL;
        MODE_NORMAL: if (fbBelowEntry && qualDone) begin
                       modeNext    = MODE_BURST;
                       burstOnNext = 1'b0;
                     end
        MODE_BURST:  if (fbAboveExit) begin
                       modeNext    = MODE_NORMAL;
                       burstOnNext = 1'b0;
                     end else if (fbAboveOn) begin
                       burstOnNext = 1'b1;
                     end else if (fbBelowOff) begin
                       burstOnNext = 1'b0;
                     end
        default:     modeNext = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ   <= MODE_IDLE;
      burstOn <= 1'b0;
    end else begin
      modeQ   <= modeNext;
      burstOn <= burstOnNext;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_SOFT:   begin gateEn = 1'b1;    limSel = LIM_RAMP;    end
      MODE_NORMAL: begin gateEn = 1'b1;    limSel = LIM_FULL;    end
      MODE_BURST:  begin gateEn = burstOn; limSel = LIM_REDUCED; end
      default:     begin gateEn = 1'b0;    limSel = LIM_OFF;     end
    endcase
  end

  assign strobe.clear     = rst || shutdown || (modeQ == MODE_IDLE);
  assign strobe.ssAdvance = (modeQ == MODE_SOFT);
  assign strobe.ssFill    = (modeQ == MODE_SOFT) && ssDone;
  assign strobe.qualCount = (modeQ == MODE_NORMAL) && fbBelowEntry && !shutdown;

  // R1: shutdown always lands in idle with the gate closed
  p_shutdown_idle_r1: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (modeQ == MODE_IDLE && !gateEn));

  // R8: exit flag in burst returns to normal next cycle
  p_burst_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_BURST && fbAboveExit && !shutdown) |=> (modeQ == MODE_NORMAL));

  // R5: burst is only reached from normal mode under low feedback
  p_burst_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(modeQ == MODE_BURST) |-> ($past(modeQ) == MODE_NORMAL && $past(fbBelowEntry)));

  // R6: burst starts with switching stopped
  p_burst_start_off_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(modeQ == MODE_BURST) |-> !gateEn);

  // R6: no flag, no change of burst gate
  p_burst_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_BURST && !shutdown && !fbAboveExit && !fbAboveOn && !fbBelowOff)
      |=> $stable(gateEn));

endmodule

// File: rtl/flyback_mode_seq.sv
module flyback_mode_seq
  import fms_pkg::*;
#(
  parameter int SS_CYCLES   = 20000,
  parameter int QUAL_CYCLES = 20000,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startPulse,
  input  logic              shutdown,
  input  logic              fbBelowEntry,
  input  logic              fbAboveOn,
  input  logic              fbBelowOff,
  input  logic              fbAboveExit,
  output logic [1:0]        mode,
  output logic              gateEn,
  output logic [1:0]        limSel,
  output logic [CODE_W-1:0] ssCode
);

  dpStrobe_t strobe;
  mode_e     modeQ;
  lim_e      limQ;
  logic      ssDone, qualDone;

  fms_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .startPulse   (startPulse),
    .shutdown     (shutdown),
    .fbBelowEntry (fbBelowEntry),
    .fbAboveOn    (fbAboveOn),
    .fbBelowOff   (fbBelowOff),
    .fbAboveExit  (fbAboveExit),
    .ssDone       (ssDone),
    .qualDone     (qualDone),
    .modeQ        (modeQ),
    .gateEn       (gateEn),
    .limSel       (limQ),
    .strobe       (strobe)
  );

  fms_dp #(
    .SS_CYCLES   (SS_CYCLES),
    .QUAL_CYCLES (QUAL_CYCLES),
    .CODE_W      (CODE_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .ssDone   (ssDone),
    .qualDone (qualDone),
    .ssCode   (ssCode)
  );

  assign mode   = modeQ;
  assign limSel = limQ;

endmodule

// File: tb/tb_flyback_mode_seq.sv
module tb_flyback_mode_seq;

  localparam int SS   = 40;
  localparam int QUAL = 12;
  localparam int W    = 4;
  localparam int CMAX = (1 << W) - 1;
  localparam int STEP = (SS + CMAX - 1) / CMAX;

  logic clk = 1'b0;
  logic rst, startPulse, shutdown;
  logic fbBelowEntry, fbAboveOn, fbBelowOff, fbAboveExit;
  logic [1:0] mode, limSel;
  logic gateEn;
  logic [W-1:0] ssCode;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flyback_mode_seq #(.SS_CYCLES(SS), .QUAL_CYCLES(QUAL), .CODE_W(W)) dut (
    .clk(clk), .rst(rst), .startPulse(startPulse), .shutdown(shutdown),
    .fbBelowEntry(fbBelowEntry), .fbAboveOn(fbAboveOn), .fbBelowOff(fbBelowOff),
    .fbAboveExit(fbAboveExit), .mode(mode), .gateEn(gateEn), .limSel(limSel),
    .ssCode(ssCode)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkState(string req, int m, int g, int l);
    chk({req, " mode"}, int'(mode), m);
    chk({req, " gate"}, int'(gateEn), g);
    chk({req, " limit"}, int'(limSel), l);
  endtask

  task automatic runSoftStart(string req);
    for (int k = 0; k < SS; k++) begin
      chk({req, " ramp"}, int'(ssCode), (k / STEP > CMAX) ? CMAX : k / STEP);
      chkState(req, 1, 1, 1);
      tick();
    end
  endtask

  initial begin
    rst = 1; startPulse = 0; shutdown = 0;
    fbBelowEntry = 0; fbAboveOn = 0; fbBelowOff = 0; fbAboveExit = 0;
    tick(); tick();
    // R1 reset state
    chkState("R1 reset", 0, 0, 0);
    chk("R1 reset code", int'(ssCode), 0);
    rst = 0;

    // R9 flags in idle do nothing
    fbBelowEntry = 1; fbAboveOn = 1; fbAboveExit = 1;
    for (int i = 0; i < 3; i++) tick();
    chkState("R9 idle flags", 0, 0, 0);
    fbBelowEntry = 0; fbAboveOn = 0; fbAboveExit = 0;

    // R2 start, R3 ramp (flags set mid ramp: R9), start pulse repeat ignored
    startPulse = 1; tick(); startPulse = 0;
    for (int k = 0; k < SS; k++) begin
      chk("R3 ramp", int'(ssCode), (k / STEP > CMAX) ? CMAX : k / STEP);
      chkState("R3 soft", 1, 1, 1);
      startPulse   = (k == 20);
      fbAboveExit  = (k == 25);
      fbBelowEntry = (k >= 30);
      tick();
    end
    startPulse = 0; fbAboveExit = 0;
    // R4 normal after exactly SS cycles
    chkState("R4 normal", 2, 1, 2);
    chk("R4 full code", int'(ssCode), CMAX);

    // R5 low-feedback cycles in soft start did not count
    for (int i = 0; i < QUAL - 1; i++) tick();
    chkState("R5 not yet", 2, 1, 2);
    fbBelowEntry = 0; tick();
    chkState("R5 restart", 2, 1, 2);
    fbBelowEntry = 1;
    for (int i = 0; i < QUAL - 1; i++) tick();
    chkState("R5 one short", 2, 1, 2);
    tick();
    // R6 burst starts off, R7 reduced limit
    chkState("R7 burst entry", 3, 0, 3);
    fbBelowEntry = 0;

    // R6 hysteresis
    fbAboveOn = 1; tick(); fbAboveOn = 0;
    chkState("R6 on", 3, 1, 3);
    tick(); chkState("R6 hold on", 3, 1, 3);
    fbBelowOff = 1; tick(); fbBelowOff = 0;
    chkState("R6 off", 3, 0, 3);
    tick(); chkState("R6 hold off", 3, 0, 3);
    fbAboveOn = 1; fbBelowOff = 1; tick();
    chkState("R6 both flags", 3, 1, 3);
    fbAboveOn = 0;

    // R8 exit colliding with burst-off flag
    fbAboveExit = 1; tick(); fbAboveExit = 0; fbBelowOff = 0;
    chkState("R8 exit", 2, 1, 2);
    chk("R8 code", int'(ssCode), CMAX);

    // R9/R6 hysteresis flags have no effect in normal
    fbAboveOn = 1; tick(); fbAboveOn = 0; fbBelowOff = 1; tick(); fbBelowOff = 0;
    chkState("R9 normal flags", 2, 1, 2);

    // re-enter burst, then shutdown (R1)
    fbBelowEntry = 1;
    for (int i = 0; i < QUAL; i++) tick();
    chkState("R5 reentry", 3, 0, 3);
    fbBelowEntry = 0; fbAboveOn = 1; tick(); fbAboveOn = 0;
    shutdown = 1; tick();
    chkState("R1 shutdown", 0, 0, 0);
    chk("R1 shutdown code", int'(ssCode), 0);

    // R1 shutdown beats simultaneous start
    startPulse = 1; tick(); startPulse = 0; shutdown = 0;
    chkState("R1 start vs shutdown", 0, 0, 0);
    tick();
    chkState("R1 stays idle", 0, 0, 0);

    // R2 fresh start, full sweep again, then reset mid normal
    startPulse = 1; tick(); startPulse = 0;
    runSoftStart("R2 second run");
    chkState("R4 second normal", 2, 1, 2);
    shutdown = 1; fbAboveExit = 1; tick(); shutdown = 0; fbAboveExit = 0;
    chkState("R1 shutdown normal", 0, 0, 0);

    // R1 synchronous reset in soft start
    startPulse = 1; tick(); startPulse = 0;
    for (int i = 0; i < 10; i++) tick();
    chk("R3 mid ramp", int'(ssCode), 10 / STEP);
    rst = 1; tick(); rst = 0;
    chkState("R1 reset soft", 0, 0, 0);
    chk("R1 reset code soft", int'(ssCode), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule